// File: doc/BRIEF.md
# Dual-Issue Dispatch Arbiter

This block picks, every cycle, which of the two oldest entries of an in-order instruction queue are sent to execution. Each entry carries a valid bit, an operation class and a count of destination operands. The arbiter weighs these against three kinds of resource: a vacancy bit per execution-unit reservation station, a count of free rename registers and a count of free completion-queue positions. Integer work can go to either of two integer units, but only the first of them can execute multiply and divide. Branches use their own branch unit, which takes one per cycle.

For each of the two candidate slots the block reports whether it dispatches, which unit it goes to and the first rename tag it receives. It also reports how many entries the queue must shift out. Rename tags come from a circular pool and are handed out in program order, starting at the pool head the caller supplies. All outputs are registered, so they describe the inputs sampled at the previous rising clock edge.

Top module: `dispatch_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every output is zero.
- R2: Dispatch is in order. The younger slot (slot 1) can dispatch only in a cycle where the older slot (slot 0) also dispatches. An invalid slot 0 blocks slot 1.
- R3: An instruction dispatches only if the `rsFree` bit of its target unit is 1. The unit codes, which are also the bit positions in `rsFree`, are: integer unit A = 0, integer unit B = 1, load/store = 2, floating point = 3, branch = 4.
- R4: No unit receives two instructions in one cycle. When both slots need the same single unit (two branches, two loads/stores, two float operations), only slot 0 dispatches.
- R5: Slot 0 needs `iq0Dst <= renameFree`. Slot 1 also needs `iq0Dst + iq1Dst <= renameFree`.
- R6: Slot 0 needs `cqFree >= 1`. Slot 1 also needs `cqFree >= 2`.
- R7: Operation class 1 (multiply/divide) goes only to unit 0. If unit 0 has no vacancy, it does not dispatch, even when unit 1 is free.
- R8: Operation class 0 (plain integer) is steered as follows.
  - When both integer units are free and both slots hold plain integer work, slot 0 goes to unit 0 and slot 1 to unit 1.
  - When both integer units are free and slot 1 is a valid multiply/divide, a plain slot 0 goes to unit 1, so that slot 1 can use unit 0.
  - Otherwise a plain integer in slot 0 prefers unit 0, and a plain integer in slot 1 prefers unit 1. Each falls back to the other integer unit if it is still free.
- R9: `disp0Tag` equals `renameHead`. `disp1Tag` equals `(renameHead + iq0Dst) mod RENAME_TAGS`. A tag output is 0 when its slot does not dispatch, and `renameHead` is assumed below `RENAME_TAGS`.
- R10: `shiftAmt` equals the number of slots that dispatched (0, 1 or 2).
- R11: The outputs in a cycle reflect the inputs sampled at the preceding rising clock edge.
- R12: Operation classes 2, 3 and 4 go to units 2, 3 and 4 respectively. Classes 5 to 7 never dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iq0Valid | input | 1 | Oldest queue entry is present |
| iq0Op | input | 3 | Operation class of the oldest entry |
| iq0Dst | input | 2 | Destination operand count of the oldest entry |
| iq1Valid | input | 1 | Second-oldest queue entry is present |
| iq1Op | input | 3 | Operation class of the second entry |
| iq1Dst | input | 2 | Destination operand count of the second entry |
| rsFree | input | 5 | Reservation-station vacancy, one bit per unit code |
| renameFree | input | $clog2(RENAME_TAGS+1) | Number of free rename registers |
| renameHead | input | $clog2(RENAME_TAGS) | Next rename tag to allocate |
| cqFree | input | $clog2(CQ_SLOTS+1) | Number of free completion-queue positions |
| disp0Valid | output | 1 | Slot 0 dispatched |
| disp0Unit | output | 3 | Unit code for slot 0 |
| disp0Tag | output | $clog2(RENAME_TAGS) | First rename tag for slot 0 |
| disp1Valid | output | 1 | Slot 1 dispatched |
| disp1Unit | output | 3 | Unit code for slot 1 |
| disp1Tag | output | $clog2(RENAME_TAGS) | First rename tag for slot 1 |
| shiftAmt | output | 2 | Entries to remove from the queue |

## Verification
The hardest situation to reach is the integer swap. It needs a plain integer in slot 0, a valid multiply/divide in slot 1, both integer units vacant, and enough rename and completion resources for both slots, all at once. Under uniform random stimulus this combination is rare. The bench therefore drives it directly, together with its near neighbours: unit 1 busy, unit 0 busy, and too few renames for slot 1. It then runs a long random phase in which vacancy bits lean towards free, so that dual dispatch and unit conflicts occur often.

// File: rtl/dispatch_arb_pkg.sv
package dispatch_arb_pkg;

  localparam int NUM_UNITS = 5;

  typedef enum logic [2:0] {
    OP_INT    = 3'd0,
    OP_MULDIV = 3'd1,
    OP_LSU    = 3'd2,
    OP_FPU    = 3'd3,
    OP_BR     = 3'd4
  } opClass_e;

  typedef enum logic [2:0] {
    U_IU1 = 3'd0,
    U_IU2 = 3'd1,
    U_LSU = 3'd2,
    U_FPU = 3'd3,
    U_BPU = 3'd4
  } unit_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic  grant0;
    logic  grant1;
    unit_e unit0;
    unit_e unit1;
  } dispStrobe_t;

endpackage

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_arb_pkg::*;
#(
  parameter int RCNT_W = 3,
  parameter int CQ_W   = 3
) (
  input  logic              iq0Valid,
  input  logic [2:0]        iq0Op,
  input  logic [1:0]        iq0Dst,
  input  logic              iq1Valid,
  input  logic [2:0]        iq1Op,
  input  logic [1:0]        iq1Dst,
  input  logic [NUM_UNITS-1:0] rsFree,
  input  logic [RCNT_W-1:0] renameFree,
  input  logic [CQ_W-1:0]   cqFree,
  output dispStrobe_t       strobe
);

  localparam int SUM_W = RCNT_W + 2;

  function automatic unit_e fixedUnit(logic [2:0] op);
    case (op)
      OP_LSU:  return U_LSU;
      OP_FPU:  return U_FPU;
      OP_BR:   return U_BPU;
      default: return U_IU1;
    endcase
  endfunction

  logic legal0, legal1, unitOk0, unitOk1, md1Pending, bothIuFree;
  logic renameOk0, renameOk1, cqOk0, cqOk1, grant0, grant1;
  unit_e unit0, unit1;
  logic [NUM_UNITS-1:0] taken, avail;
  logic [SUM_W-1:0] need0, need1, haveRen;

  always_comb begin
    legal0     = iq0Op <= 3'd4;
    legal1     = iq1Op <= 3'd4;
    md1Pending = iq1Valid && (iq1Op == OP_MULDIV);
    bothIuFree = rsFree[U_IU1] && rsFree[U_IU2];

    // slot 0 unit choice
    unit0   = fixedUnit(iq0Op);
    unitOk0 = rsFree[unit0];
    if (iq0Op == OP_MULDIV) begin
      unit0   = U_IU1;
      unitOk0 = rsFree[U_IU1];
    end else if (iq0Op == OP_INT) begin
      if (md1Pending && bothIuFree) unit0 = U_IU2;
      else if (rsFree[U_IU1])       unit0 = U_IU1;
      else                          unit0 = U_IU2;
      unitOk0 = rsFree[U_IU1] || rsFree[U_IU2];
    end

    haveRen   = SUM_W'(renameFree);
    need0     = SUM_W'(iq0Dst);
    need1     = SUM_W'(iq0Dst) + SUM_W'(iq1Dst);
    renameOk0 = need0 <= haveRen;
    renameOk1 = need1 <= haveRen;
    cqOk0     = cqFree >= CQ_W'(1);
    cqOk1     = cqFree >= CQ_W'(2);

    grant0 = iq0Valid && legal0 && unitOk0 && renameOk0 && cqOk0;

    // slot 1 sees what slot 0 left over
    taken = grant0 ? (NUM_UNITS'(1) << unit0) : '0;
    avail = rsFree & ~taken;

    unit1   = fixedUnit(iq1Op);
    unitOk1 = avail[unit1];
    if (iq1Op == OP_MULDIV) begin
      unit1   = U_IU1;
      unitOk1 = avail[U_IU1];
    end else if (iq1Op == OP_INT) begin
      unit1   = avail[U_IU2] ? U_IU2 : U_IU1;
      unitOk1 = avail[U_IU1] || avail[U_IU2];
    end

    grant1 = grant0 && iq1Valid && legal1 && unitOk1 && renameOk1 && cqOk1;

    strobe.grant0 = grant0;
    strobe.grant1 = grant1;
    strobe.unit0  = unit0;
    strobe.unit1  = unit1;
  end

endmodule

// File: rtl/dispatch_dp.sv
module dispatch_dp
  import dispatch_arb_pkg::*;
#(
  parameter int RENAME_TAGS = 6,
  parameter int TAG_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dispStrobe_t      strobe,
  input  logic [1:0]       iq0Dst,
  input  logic [TAG_W-1:0] renameHead,
  output logic             disp0Valid,
  output logic [2:0]       disp0Unit,
  output logic [TAG_W-1:0] disp0Tag,
  output logic             disp1Valid,
  output logic [2:0]       disp1Unit,
  output logic [TAG_W-1:0] disp1Tag,
  output logic [1:0]       shiftAmt
);

  localparam int WIDE_W = TAG_W + 2;

  logic [WIDE_W-1:0] tagSum, tagWrap;
  logic [TAG_W-1:0]  nextTag1;

  always_comb begin
    tagSum  = WIDE_W'(renameHead) + WIDE_W'(iq0Dst);
    tagWrap = (tagSum >= WIDE_W'(RENAME_TAGS)) ? tagSum - WIDE_W'(RENAME_TAGS) : tagSum;
    nextTag1 = tagWrap[TAG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp0Valid <= 1'b0;
      disp0Unit  <= '0;
      disp0Tag   <= '0;
      disp1Valid <= 1'b0;
      disp1Unit  <= '0;
      disp1Tag   <= '0;
      shiftAmt   <= '0;
    end else begin
      disp0Valid <= strobe.grant0;
      disp0Unit  <= strobe.grant0 ? strobe.unit0 : 3'd0;
      disp0Tag   <= strobe.grant0 ? renameHead : '0;
      disp1Valid <= strobe.grant1;
      disp1Unit  <= strobe.grant1 ? strobe.unit1 : 3'd0;
      disp1Tag   <= strobe.grant1 ? nextTag1 : '0;
      shiftAmt   <= 2'(strobe.grant0) + 2'(strobe.grant1);
    end
  end

  // R10
  shift_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shiftAmt == 2'($countones({disp0Valid, disp1Valid})));

endmodule

// File: rtl/dispatch_arbiter.sv
module dispatch_arbiter
  import dispatch_arb_pkg::*;
#(
  parameter int RENAME_TAGS = 6,
  parameter int CQ_SLOTS    = 6,
  localparam int TAG_W  = $clog2(RENAME_TAGS),
  localparam int RCNT_W = $clog2(RENAME_TAGS + 1),
  localparam int CQ_W   = $clog2(CQ_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iq0Valid,
  input  logic [2:0]        iq0Op,
  input  logic [1:0]        iq0Dst,
  input  logic              iq1Valid,
  input  logic [2:0]        iq1Op,
  input  logic [1:0]        iq1Dst,
  input  logic [4:0]        rsFree,
  input  logic [RCNT_W-1:0] renameFree,
  input  logic [TAG_W-1:0]  renameHead,
  input  logic [CQ_W-1:0]   cqFree,
  output logic              disp0Valid,
  output logic [2:0]        disp0Unit,
  output logic [TAG_W-1:0]  disp0Tag,
  output logic              disp1Valid,
  output logic [2:0]        disp1Unit,
  output logic [TAG_W-1:0]  disp1Tag,
  output logic [1:0]        shiftAmt
);

  dispStrobe_t strobe;

  dispatch_ctrl #(.RCNT_W(RCNT_W), .CQ_W(CQ_W)) u_ctrl (
    .iq0Valid(iq0Valid), .iq0Op(iq0Op), .iq0Dst(iq0Dst),
    .iq1Valid(iq1Valid), .iq1Op(iq1Op), .iq1Dst(iq1Dst),
    .rsFree(rsFree), .renameFree(renameFree), .cqFree(cqFree),
    .strobe(strobe)
  );

  dispatch_dp #(.RENAME_TAGS(RENAME_TAGS), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .iq0Dst(iq0Dst), .renameHead(renameHead),
    .disp0Valid(disp0Valid), .disp0Unit(disp0Unit), .disp0Tag(disp0Tag),
    .disp1Valid(disp1Valid), .disp1Unit(disp1Unit), .disp1Tag(disp1Tag),
    .shiftAmt(shiftAmt)
  );

  // R2
  in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp1Valid |-> disp0Valid);

  // R4
  unit_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp0Valid && disp1Valid) |-> (disp0Unit != disp1Unit));

  // R3
  vacancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp0Valid |-> |(($past(rsFree) >> disp0Unit) & 5'd1));

  // R7
  muldiv_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp0Valid && $past(iq0Op) == OP_MULDIV) |-> (disp0Unit == U_IU1));

  // R7
  muldiv_slot1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp1Valid && $past(iq1Op) == OP_MULDIV) |-> (disp1Unit == U_IU1));

  // R5
  rename_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp0Valid |-> ({1'b0, $past(iq0Dst)} <= 3'($past(renameFree))));

  // R6
  cq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp1Valid |-> ($past(cqFree) >= CQ_W'(2)));

endmodule

// File: tb/dispatch_arbiter_tb.sv
`timescale 1ns/1ps
module dispatch_arbiter_tb;

  localparam int RT = 6;
  localparam int CQ = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic iq0Valid, iq1Valid;
  logic [2:0] iq0Op, iq1Op;
  logic [1:0] iq0Dst, iq1Dst;
  logic [4:0] rsFree;
  logic [2:0] renameFree;
  logic [2:0] renameHead;
  logic [2:0] cqFree;
  logic disp0Valid, disp1Valid;
  logic [2:0] disp0Unit, disp1Unit;
  logic [2:0] disp0Tag, disp1Tag;
  logic [1:0] shiftAmt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dispatch_arbiter #(.RENAME_TAGS(RT), .CQ_SLOTS(CQ)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .iq0Valid(iq0Valid), .iq0Op(iq0Op), .iq0Dst(iq0Dst),
    .iq1Valid(iq1Valid), .iq1Op(iq1Op), .iq1Dst(iq1Dst),
    .rsFree(rsFree), .renameFree(renameFree), .renameHead(renameHead),
    .cqFree(cqFree),
    .disp0Valid(disp0Valid), .disp0Unit(disp0Unit), .disp0Tag(disp0Tag),
    .disp1Valid(disp1Valid), .disp1Unit(disp1Unit), .disp1Tag(disp1Tag),
    .shiftAmt(shiftAmt)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference: unit picked for an op given vacancy; -1 if none
  function automatic int pick(int op, logic [4:0] avail, bit youngSlot, bit steer);
    case (op)
      0: begin
        if (youngSlot) return avail[1] ? 1 : (avail[0] ? 0 : -1);
        if (steer) return 1;
        return avail[0] ? 0 : (avail[1] ? 1 : -1);
      end
      1: return avail[0] ? 0 : -1;
      2, 3, 4: return avail[op] ? op : -1;
      default: return -1;
    endcase
  endfunction

  task automatic apply(bit v0, int o0, int d0, bit v1, int o1, int d1,
                       logic [4:0] rs, int rf, int hd, int cq, string tag);
    int u0, u1;
    bit ok0, ok1, steer;
    int eU0, eU1, eT0, eT1;
    logic [4:0] left;
    iq0Valid = v0; iq0Op = 3'(o0); iq0Dst = 2'(d0);
    iq1Valid = v1; iq1Op = 3'(o1); iq1Dst = 2'(d1);
    rsFree = rs; renameFree = 3'(rf); renameHead = 3'(hd); cqFree = 3'(cq);
    steer = v1 && (o1 == 1) && rs[0] && rs[1];
    u0  = pick(o0, rs, 1'b0, steer);
    ok0 = v0 && (u0 >= 0) && (d0 <= rf) && (cq >= 1);
    left = ok0 ? (rs & ~(5'd1 << u0)) : rs;
    u1  = pick(o1, left, 1'b1, 1'b0);
    ok1 = ok0 && v1 && (u1 >= 0) && (d0 + d1 <= rf) && (cq >= 2);
    eU0 = ok0 ? u0 : 0;
    eU1 = ok1 ? u1 : 0;
    eT0 = ok0 ? hd : 0;
    eT1 = ok1 ? (hd + d0) % RT : 0;
    @(negedge clk);
    // R11: outputs now reflect inputs captured at the edge just passed
    check(tag, "disp0Valid", int'(disp0Valid), int'(ok0));
    check(tag, "disp1Valid", int'(disp1Valid), int'(ok1));
    check(tag, "disp0Unit", int'(disp0Unit), eU0);
    check(tag, "disp1Unit", int'(disp1Unit), eU1);
    check("R9", "disp0Tag", int'(disp0Tag), eT0);
    check("R9", "disp1Tag", int'(disp1Tag), eT1);
    check("R10", "shiftAmt", int'(shiftAmt), int'(ok0) + int'(ok1));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rst_n = 1'b0;
    iq0Valid = 1; iq0Op = 0; iq0Dst = 1;
    iq1Valid = 1; iq1Op = 0; iq1Dst = 1;
    rsFree = 5'h1f; renameFree = 6; renameHead = 0; cqFree = 6;
    repeat (3) @(negedge clk);
    // R1: held in reset with dispatchable inputs
    check("R1", "disp0Valid", int'(disp0Valid), 0);
    check("R1", "disp1Valid", int'(disp1Valid), 0);
    check("R1", "shiftAmt", int'(shiftAmt), 0);
    check("R1", "disp0Tag", int'(disp0Tag), 0);
    rst_n = 1'b1;

    // R8 plain pair
    apply(1, 0, 1, 1, 0, 1, 5'h1f, 6, 0, 6, "R8");
    // R8 swap: plain then multiply/divide
    apply(1, 0, 1, 1, 1, 1, 5'h1f, 6, 2, 6, "R8");
    // R8 swap with unit 1 busy: slot 1 blocked
    apply(1, 0, 1, 1, 1, 1, 5'b11101, 6, 2, 6, "R8");
    // R8 unit 0 busy, single plain goes to unit 1
    apply(1, 0, 1, 0, 0, 0, 5'b11110, 6, 1, 6, "R8");
    // R8 swap decided even when renames starve slot 1
    apply(1, 0, 2, 1, 1, 2, 5'h1f, 3, 4, 6, "R8");
    // R7 multiply/divide with unit 0 busy
    apply(1, 1, 1, 1, 0, 1, 5'b11110, 6, 0, 6, "R7");
    // R7 multiply/divide then plain
    apply(1, 1, 1, 1, 0, 1, 5'h1f, 6, 0, 6, "R7");
    // R12 class routing
    apply(1, 2, 1, 1, 3, 1, 5'h1f, 6, 3, 6, "R12");
    apply(1, 4, 0, 1, 2, 1, 5'h1f, 6, 3, 6, "R12");
    apply(1, 6, 0, 1, 0, 1, 5'h1f, 6, 3, 6, "R12");
    // R3 vacancy
    apply(1, 2, 1, 1, 0, 1, 5'b11011, 6, 0, 6, "R3");
    apply(1, 0, 1, 1, 3, 1, 5'b10111, 6, 0, 6, "R3");
    // R4 same unit twice
    apply(1, 4, 0, 1, 4, 0, 5'h1f, 6, 0, 6, "R4");
    apply(1, 2, 1, 1, 2, 1, 5'h1f, 6, 0, 6, "R4");
    // R5 rename gating
    apply(1, 0, 1, 1, 0, 1, 5'h1f, 1, 0, 6, "R5");
    apply(1, 0, 2, 1, 0, 0, 5'h1f, 1, 0, 6, "R5");
    apply(1, 0, 1, 1, 0, 2, 5'h1f, 3, 0, 6, "R5");
    // R6 completion gating
    apply(1, 0, 1, 1, 0, 1, 5'h1f, 6, 0, 1, "R6");
    apply(1, 0, 1, 1, 0, 1, 5'h1f, 6, 0, 0, "R6");
    // R2 in-order blocking
    apply(0, 0, 1, 1, 0, 1, 5'h1f, 6, 0, 6, "R2");
    apply(1, 3, 1, 1, 0, 1, 5'b10111, 6, 0, 6, "R2");
    // R9 tag wrap
    apply(1, 0, 2, 1, 2, 1, 5'h1f, 6, 5, 6, "R9");
    apply(1, 3, 1, 1, 0, 1, 5'h1f, 6, 5, 6, "R9");

    // R11 random phase
    for (int i = 0; i < 4000; i++) begin
      int o0, o1;
      logic [4:0] rs;
      o0 = ($urandom % 10 == 0) ? 5 + $urandom % 3 : $urandom % 5;
      o1 = ($urandom % 10 == 0) ? 5 + $urandom % 3 : $urandom % 5;
      for (int b = 0; b < 5; b++) rs[b] = ($urandom % 4) != 0;
      apply(($urandom % 6) != 0, o0, $urandom % 3,
            ($urandom % 6) != 0, o1, $urandom % 3,
            rs, $urandom % 7, $urandom % RT, $urandom % 7, "R11");
    end

    finishRun();
  end

endmodule